// File: doc/BRIEF.md
# DMA Transfer Submission Queue Controller

This block is the register-side front end of a single-channel DMA engine. Software stages a descriptor's flags, reads the identifier the hardware will assign, and commits the descriptor with a write to the start register. The block moves committed descriptors into an ordered queue, hands them one at a time to a data mover over a valid/ready handshake, and tracks every transfer that has been accepted but not yet finished by its 5-bit identifier.

When the mover reports a finished transfer, the block sets that transfer's bit in a done bitmap and raises the end-of-transfer interrupt cause. Acceptance of a committed descriptor frees the submission slot and raises the start-of-transfer cause. Causes are held in a write-1-to-clear pending register and can be masked before they reach the single interrupt line. Writing control with the enable bit clear aborts everything queued or in flight.

Top module: `dmaq_top`

## Requirements
- R1: After reset the next-ID register (0x404) reads 0, start (0x408), pending (0x084), done bitmap (0x428) and status (0x430) read 0, the mask (0x080) reads 3 (both causes masked), irq is 0 and descValid is 0.
- R2: A write of 1 to start (0x408) while control bit 0 (enable) is set captures the flag register (0x40C, bit 0 cyclic, bit 1 last, bit 2 partial report) into the submission slot; start reads 1 while the slot is occupied. The slot is accepted into the queue on the following clock edge when there is room, setting pending bit 0. A start write while enable is 0 is ignored.
- R3: Each accepted descriptor receives the ID shown in the next-ID register, which then advances by one modulo 32 (31 is followed by 0).
- R4: The queue holds QDEPTH descriptors (default 4); when it is full the slot stays occupied and start keeps reading 1. Status bits 15:8 give the queue occupancy.
- R5: descValid is asserted only while control bit 0 is 1 and bit 1 (pause) is 0; descriptors leave in acceptance order with their ID on descId and flags on descFlags, and the active-ID register (0x42C) holds the ID of the last one handed over.
- R6: A completion (cplValid with cplId) for an in-flight ID sets done bit cplId and pending bit 1; a completion for an ID that is not in flight changes nothing.
- R7: Reading the done bitmap returns the set bits and clears them; a completion in the same cycle as the read is not in the returned value and appears on the next read.
- R8: An ID is not assigned while its done bit is still set or it is still in flight; the slot waits until it is free.
- R9: A transfer committed with flag bit 0 (cyclic) stays in flight after a completion, so further completions of that ID set its done bit again.
- R10: Writing control with bit 0 clear empties the slot and the queue, drops all in-flight IDs and lowers descValid; the done bitmap and next ID are kept.
- R11: Writing the pending register clears the bits written as 1; a cause arriving in the same cycle stays set.
- R12: irq is the OR of pending bits whose mask bit is 0, and the source register (0x088) reads pending AND NOT mask.
- R13: Status bit 0 reads 1 while the slot is occupied, the queue is non-empty or any ID is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe (read side effects apply at the edge) |
| busAddr | input | 12 | Byte address of the register |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, valid in the cycle of busRdEn |
| irq | output | 1 | Interrupt request |
| descValid | output | 1 | Descriptor offered to the data mover |
| descReady | input | 1 | Data mover takes the descriptor |
| descId | output | ID_W | ID of the offered descriptor |
| descFlags | output | 3 | Flags of the offered descriptor |
| cplValid | input | 1 | Data mover reports a finished transfer |
| cplId | input | ID_W | ID of the finished transfer |

## Verification
Two collisions matter most: a done-bitmap read that coincides with a completion, and a write-1-to-clear of the pending register that coincides with a new end-of-transfer cause. The bench drives the bus read (or write) and the completion in the same cycle, then checks that the returned bitmap leaves out the new bit while a following read shows it, and that the pending bit survives the clear. ID wrap-around with a stale done bit is provoked by running 32 transfers without reading the bitmap and checking that the slot stalls until the read.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;
  localparam int REG_W  = 32;
  localparam int FLAG_W = 3;

  localparam logic [11:0] ADR_IMASK  = 12'h080;
  localparam logic [11:0] ADR_IPEND  = 12'h084;
  localparam logic [11:0] ADR_ISRC   = 12'h088;
  localparam logic [11:0] ADR_CTL    = 12'h400;
  localparam logic [11:0] ADR_NEXTID = 12'h404;
  localparam logic [11:0] ADR_START  = 12'h408;
  localparam logic [11:0] ADR_FLAGS  = 12'h40C;
  localparam logic [11:0] ADR_DONE   = 12'h428;
  localparam logic [11:0] ADR_ACTID  = 12'h42C;
  localparam logic [11:0] ADR_STATUS = 12'h430;

  typedef struct packed {
    logic startCommit;
    logic flush;
    logic doneRead;
    logic enabled;
    logic run;
  } dmaqStrobe_t;
endpackage

// File: rtl/dmaq_ctrl.sv
module dmaq_ctrl
  import dmaq_pkg::*;
#(
  parameter int ID_W  = 5,
  parameter int CNT_W = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   busWrEn,
  input  logic                   busRdEn,
  input  logic [11:0]            busAddr,
  input  logic [REG_W-1:0]       busWrData,
  output logic [REG_W-1:0]       busRdData,
  output logic                   irq,
  output logic [FLAG_W-1:0]      flagsStaged,
  output dmaqStrobe_t            strobe,
  input  logic                   sotEvt,
  input  logic                   eotEvt,
  input  logic [ID_W-1:0]        nextId,
  input  logic [ID_W-1:0]        activeId,
  input  logic                   slotBusy,
  input  logic [(1<<ID_W)-1:0]   doneMap,
  input  logic [CNT_W-1:0]       queueCount,
  input  logic                   busy
);
  localparam int NUM_IDS = 1 << ID_W;

  logic [1:0] ctlReg, maskReg, pendReg;
  logic [1:0] unmasked;
  logic       wrCtl, wrMask, wrPend, wrFlags, wrStart;
  logic       unusedWrBits;

  assign unusedWrBits = ^busWrData[REG_W-1:FLAG_W];

  assign wrCtl   = busWrEn && (busAddr == ADR_CTL);
  assign wrMask  = busWrEn && (busAddr == ADR_IMASK);
  assign wrPend  = busWrEn && (busAddr == ADR_IPEND);
  assign wrFlags = busWrEn && (busAddr == ADR_FLAGS);
  assign wrStart = busWrEn && (busAddr == ADR_START);

  assign strobe.startCommit = wrStart && busWrData[0] && ctlReg[0];
  assign strobe.flush       = wrCtl && !busWrData[0];
  assign strobe.doneRead    = busRdEn && (busAddr == ADR_DONE);
  assign strobe.enabled     = ctlReg[0];
  assign strobe.run         = ctlReg[0] && !ctlReg[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlReg      <= 2'b00;
      maskReg     <= 2'b11;
      pendReg     <= 2'b00;
      flagsStaged <= '0;
    end else begin
      if (wrCtl)   ctlReg      <= busWrData[1:0];
      if (wrMask)  maskReg     <= busWrData[1:0];
      if (wrFlags) flagsStaged <= busWrData[FLAG_W-1:0];
      // clear first, new causes win
      pendReg <= (pendReg & ~(wrPend ? busWrData[1:0] : 2'b00)) | {eotEvt, sotEvt};
    end
  end

  assign unmasked = pendReg & ~maskReg;
  assign irq      = |unmasked;

  always_comb begin
    busRdData = '0;
    unique case (busAddr)
      ADR_IMASK:  busRdData = REG_W'(maskReg);
      ADR_IPEND:  busRdData = REG_W'(pendReg);
      ADR_ISRC:   busRdData = REG_W'(unmasked);
      ADR_CTL:    busRdData = REG_W'(ctlReg);
      ADR_NEXTID: busRdData = REG_W'(nextId);
      ADR_START:  busRdData = REG_W'(slotBusy);
      ADR_FLAGS:  busRdData = REG_W'(flagsStaged);
      ADR_DONE:   busRdData = REG_W'(doneMap);
      ADR_ACTID:  busRdData = REG_W'(activeId);
      ADR_STATUS: busRdData = {16'h0, 8'(queueCount), 7'h0, busy};
      default:    busRdData = '0;
    endcase
  end

  initial begin
    if (NUM_IDS > REG_W) $error("ID space wider than the done register");
  end

  // R11: full write-1-to-clear with no new cause leaves nothing pending
  p_w1c_clears_r11: assert property (@(posedge clk) disable iff (!rstN)
    (wrPend && busWrData[1:0] == 2'b11 && !sotEvt && !eotEvt) |=> (pendReg == 2'b00));

  // R11: a new end-of-transfer cause survives a simultaneous clear
  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rstN)
    eotEvt |=> pendReg[1]);
endmodule

// File: rtl/dmaq_datapath.sv
module dmaq_datapath
  import dmaq_pkg::*;
#(
  parameter int QDEPTH = 4,
  parameter int ID_W   = 5,
  parameter int CNT_W  = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dmaqStrobe_t          strobe,
  input  logic [FLAG_W-1:0]    flagsStaged,
  output logic                 descValid,
  input  logic                 descReady,
  output logic [ID_W-1:0]      descId,
  output logic [FLAG_W-1:0]    descFlags,
  input  logic                 cplValid,
  input  logic [ID_W-1:0]      cplId,
  output logic [ID_W-1:0]      nextId,
  output logic [ID_W-1:0]      activeId,
  output logic                 slotBusy,
  output logic [(1<<ID_W)-1:0] doneMap,
  output logic [CNT_W-1:0]     queueCount,
  output logic                 busy,
  output logic                 sotEvt,
  output logic                 eotEvt
);
  localparam int NUM_IDS = 1 << ID_W;
  localparam int PTR_W   = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;

  logic [FLAG_W-1:0]  slotFlags;
  logic [ID_W-1:0]    qId    [QDEPTH];
  logic [FLAG_W-1:0]  qFlags [QDEPTH];
  logic [PTR_W-1:0]   rdPtr, wrPtr;
  logic [NUM_IDS-1:0] inFlight, cyclicMap;
  logic [NUM_IDS-1:0] cplBit, allocBit;
  logic               idFree, accept, handoff, cplHit, queueFull;

  function automatic logic [PTR_W-1:0] ptrInc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(QDEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign queueFull = (queueCount == CNT_W'(QDEPTH));
  assign idFree    = !inFlight[nextId] && !doneMap[nextId];
  assign accept    = slotBusy && strobe.enabled && !queueFull && idFree && !strobe.flush;
  assign descValid = strobe.run && (queueCount != '0);
  assign handoff   = descValid && descReady;
  assign descId    = qId[rdPtr];
  assign descFlags = qFlags[rdPtr];
  assign cplHit    = cplValid && inFlight[cplId] && !strobe.flush;
  assign cplBit    = NUM_IDS'(1) << cplId;
  assign allocBit  = NUM_IDS'(1) << nextId;
  assign sotEvt    = accept;
  assign eotEvt    = cplHit;
  assign busy      = slotBusy || (queueCount != '0) || (|inFlight);

  // submission slot
  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotBusy  <= 1'b0;
      slotFlags <= '0;
    end else if (strobe.flush || accept) begin
      slotBusy <= 1'b0;
    end else if (strobe.startCommit && !slotBusy) begin
      slotBusy  <= 1'b1;
      slotFlags <= flagsStaged;
    end
  end

  // ordered queue toward the mover
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr      <= '0;
      wrPtr      <= '0;
      queueCount <= '0;
      for (int i = 0; i < QDEPTH; i++) begin
        qId[i]    <= '0;
        qFlags[i] <= '0;
      end
    end else if (strobe.flush) begin
      rdPtr      <= '0;
      wrPtr      <= '0;
      queueCount <= '0;
    end else begin
      if (accept) begin
        qId[wrPtr]    <= nextId;
        qFlags[wrPtr] <= slotFlags;
        wrPtr         <= ptrInc(wrPtr);
      end
      if (handoff) rdPtr <= ptrInc(rdPtr);
      queueCount <= queueCount + CNT_W'(accept) - CNT_W'(handoff);
    end
  end

  // ID allocation, in-flight tracking and completion bitmap
  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextId    <= '0;
      activeId  <= '0;
      inFlight  <= '0;
      cyclicMap <= '0;
      doneMap   <= '0;
    end else begin
      if (accept) nextId <= nextId + 1'b1;
      if (handoff) activeId <= descId;
      if (strobe.flush) begin
        inFlight  <= '0;
        cyclicMap <= '0;
      end else begin
        inFlight  <= (inFlight & ~((cplHit && !cyclicMap[cplId]) ? cplBit : '0))
                   | (accept ? allocBit : '0);
        cyclicMap <= (cyclicMap & ~((cplHit && !cyclicMap[cplId]) ? cplBit : '0))
                   | ((accept && slotFlags[0]) ? allocBit : '0);
      end
      doneMap <= (strobe.doneRead ? '0 : doneMap) | (cplHit ? cplBit : '0);
    end
  end

  // R4: occupancy never exceeds the configured depth
  p_queue_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    queueCount <= CNT_W'(QDEPTH));

  // R3: every acceptance advances the next ID by one
  p_next_id_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> (nextId == $past(nextId) + 1'b1));

  // R7: a completion that meets a bitmap read is kept for the next read
  p_done_kept_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cplHit && strobe.doneRead) |=> doneMap[$past(cplId)]);

  // R10: an abort leaves nothing queued, staged or in flight
  p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flush |=> (queueCount == '0 && !slotBusy && inFlight == '0));

  // R9: a cyclic transfer stays in flight after completing
  p_cyclic_stays_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cplHit && cyclicMap[cplId]) |=> inFlight[$past(cplId)]);
endmodule

// File: rtl/dmaq_top.sv
module dmaq_top
  import dmaq_pkg::*;
#(
  parameter int QDEPTH = 4,
  parameter int ID_W   = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWrEn,
  input  logic             busRdEn,
  input  logic [11:0]      busAddr,
  input  logic [31:0]      busWrData,
  output logic [31:0]      busRdData,
  output logic             irq,
  output logic             descValid,
  input  logic             descReady,
  output logic [ID_W-1:0]  descId,
  output logic [2:0]       descFlags,
  input  logic             cplValid,
  input  logic [ID_W-1:0]  cplId
);
  localparam int CNT_W   = $clog2(QDEPTH + 1);
  localparam int NUM_IDS = 1 << ID_W;

  dmaqStrobe_t        strobe;
  logic [FLAG_W-1:0]  flagsStaged;
  logic               sotEvt, eotEvt, slotBusy, busy;
  logic [ID_W-1:0]    nextId, activeId;
  logic [NUM_IDS-1:0] doneMap;
  logic [CNT_W-1:0]   queueCount;

  dmaq_ctrl #(.ID_W(ID_W), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .irq(irq),
    .flagsStaged(flagsStaged), .strobe(strobe),
    .sotEvt(sotEvt), .eotEvt(eotEvt),
    .nextId(nextId), .activeId(activeId), .slotBusy(slotBusy),
    .doneMap(doneMap), .queueCount(queueCount), .busy(busy)
  );

  dmaq_datapath #(.QDEPTH(QDEPTH), .ID_W(ID_W), .CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .flagsStaged(flagsStaged),
    .descValid(descValid), .descReady(descReady),
    .descId(descId), .descFlags(descFlags),
    .cplValid(cplValid), .cplId(cplId),
    .nextId(nextId), .activeId(activeId), .slotBusy(slotBusy),
    .doneMap(doneMap), .queueCount(queueCount), .busy(busy),
    .sotEvt(sotEvt), .eotEvt(eotEvt)
  );
endmodule

// File: tb/tb_dmaq_top.sv
module tb_dmaq_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] IMASK = 12'h080, IPEND = 12'h084, ISRC = 12'h088;
  localparam logic [11:0] CTL = 12'h400, NEXTID = 12'h404, START = 12'h408;
  localparam logic [11:0] FLAGS = 12'h40C, DONE = 12'h428, ACTID = 12'h42C;
  localparam logic [11:0] STATUS = 12'h430;

  logic clk = 1'b0, rstN = 1'b0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWrData = '0, busRdData;
  logic irq, descValid, descReady = 1'b0;
  logic [4:0] descId, cplId = '0;
  logic [2:0] descFlags;
  logic cplValid = 1'b0;

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  dmaq_top dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .irq(irq), .descValid(descValid), .descReady(descReady),
    .descId(descId), .descFlags(descFlags), .cplValid(cplValid), .cplId(cplId)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rdChk(logic [11:0] a, logic [31:0] exp, string tag);
    busRdEn = 1'b1; busAddr = a;
    #1 chk(tag, busRdData, exp);
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic cpl(logic [4:0] id);
    cplValid = 1'b1; cplId = id;
    @(negedge clk);
    cplValid = 1'b0;
  endtask

  task automatic handOne();
    descReady = 1'b1;
    @(negedge clk);
    descReady = 1'b0;
  endtask

  task automatic submit();
    wr(START, 32'd1);
    @(negedge clk);
  endtask

  task automatic tReset();
    rdChk(NEXTID, 0, "R1 next id");
    rdChk(START, 0, "R1 start");
    rdChk(IPEND, 0, "R1 pending");
    rdChk(DONE, 0, "R1 done");
    rdChk(STATUS, 0, "R1 status");
    rdChk(IMASK, 3, "R1 mask");
    chk("R1 irq", irq, 0);
    chk("R1 descValid", descValid, 0);
  endtask

  task automatic tDisabledStart();
    wr(START, 1);
    @(negedge clk);
    rdChk(START, 0, "R2 start ignored when disabled");
    rdChk(NEXTID, 0, "R2 no id used when disabled");
    wr(CTL, 1);
    wr(IMASK, 0);
  endtask

  task automatic tBasic();
    wr(FLAGS, 4);
    wr(START, 1);
    rdChk(START, 1, "R2 slot occupied");
    chk("R5 descValid", descValid, 1);
    chk("R3 first id", descId, 0);
    chk("R2 flags carried", descFlags, 4);
    rdChk(IPEND, 1, "R2 sot pending");
    chk("R12 irq unmasked", irq, 1);
    rdChk(ISRC, 1, "R12 source");
    wr(IMASK, 1);
    chk("R12 irq masked", irq, 0);
    rdChk(ISRC, 0, "R12 source masked");
    wr(IMASK, 0);
    handOne();
    rdChk(ACTID, 0, "R5 active id");
    rdChk(NEXTID, 1, "R3 next id advanced");
    cpl(0);
    rdChk(DONE, 1, "R6 done bit 0");
    rdChk(IPEND, 3, "R6 eot pending");
    rdChk(DONE, 0, "R7 cleared on read");
    wr(IPEND, 3);
    rdChk(IPEND, 0, "R11 cleared");
    chk("R12 irq low", irq, 0);
    wr(FLAGS, 0);
  endtask

  task automatic tOrderFull();
    for (int i = 0; i < 5; i++) submit();
    rdChk(START, 1, "R4 slot held while full");
    rdChk(STATUS, 32'h0401, "R4 occupancy");
    descReady = 1'b1;
    for (int k = 0; k < 5; k++) begin
      chk("R5 valid in order", descValid, 1);
      chk("R5 order", descId, 32'(k + 1));
      @(negedge clk);
    end
    descReady = 1'b0;
    rdChk(ACTID, 5, "R5 active id last");
    for (int i = 1; i <= 5; i++) cpl(5'(i));
    rdChk(DONE, 32'h3E, "R6 done bits 1..5");
    // pause
    wr(CTL, 3);
    submit();
    chk("R5 paused no valid", descValid, 0);
    wr(CTL, 1);
    chk("R5 resumed valid", descValid, 1);
    chk("R5 resumed id", descId, 6);
    handOne();
    cpl(6);
    rdChk(DONE, 32'h40, "R6 done bit 6");
    wr(IPEND, 3);
  endtask

  task automatic tCyclic();
    wr(FLAGS, 1);
    submit();
    handOne();
    cpl(7);
    rdChk(DONE, 32'h80, "R9 first period");
    rdChk(STATUS, 1, "R13 busy while cyclic");
    cpl(7);
    rdChk(DONE, 32'h80, "R9 second period");
    wr(IPEND, 3);
    wr(CTL, 0);
    rdChk(STATUS, 0, "R10 idle after abort");
    cpl(7);
    rdChk(DONE, 0, "R6 stale completion ignored");
    rdChk(IPEND, 0, "R6 no eot for stale id");
    wr(CTL, 1);
    wr(FLAGS, 0);
  endtask

  task automatic tFlush();
    submit();
    submit();
    chk("R10 queued valid", descValid, 1);
    wr(CTL, 0);
    chk("R10 valid dropped", descValid, 0);
    rdChk(STATUS, 0, "R10 queue empty");
    rdChk(START, 0, "R10 slot empty");
    wr(CTL, 1);
    rdChk(NEXTID, 10, "R10 next id kept");
    chk("R10 nothing left", descValid, 0);
    wr(IPEND, 3);
  endtask

  task automatic tSameCycle();
    submit(); handOne();
    submit(); handOne();
    submit(); handOne();
    wr(IPEND, 3);
    cpl(10);
    busRdEn = 1'b1; busAddr = DONE; cplValid = 1'b1; cplId = 5'd11;
    #1 chk("R7 read excludes same-cycle cpl", busRdData, 32'h400);
    @(negedge clk);
    busRdEn = 1'b0; cplValid = 1'b0;
    rdChk(DONE, 32'h800, "R7 same-cycle cpl kept");
    wr(IPEND, 3);
    busWrEn = 1'b1; busAddr = IPEND; busWrData = 2; cplValid = 1'b1; cplId = 5'd12;
    @(negedge clk);
    busWrEn = 1'b0; cplValid = 1'b0;
    rdChk(IPEND, 2, "R11 set wins over clear");
    chk("R12 irq from eot", irq, 1);
    rdChk(DONE, 32'h1000, "R6 done bit 12");
    wr(IPEND, 3);
  endtask

  task automatic tWrap();
    for (int i = 0; i < 32; i++) begin
      logic [4:0] id;
      id = 5'((13 + i) % 32);
      submit();
      handOne();
      cpl(id);
      if (id == 5'd31) rdChk(NEXTID, 0, "R3 wrap to 0");
    end
    rdChk(NEXTID, 13, "R3 id after full lap");
    wr(START, 1);
    @(negedge clk);
    @(negedge clk);
    rdChk(START, 1, "R8 stalled on pending done");
    rdChk(DONE, 32'hFFFF_FFFF, "R8 all done bits");
    @(negedge clk);
    rdChk(START, 0, "R8 accepted after read");
    rdChk(NEXTID, 14, "R8 id reused");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tDisabledStart();
    tBasic();
    tOrderFull();
    tCyclic();
    tFlush();
    tSameCycle();
    tWrap();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog R1 act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule